// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block predicts whether a conditional branch is taken or not. It is meant for the fetch stage of a pipelined core. A shift register keeps the outcomes of recently resolved branches. That history is XORed with a slice of the fetch PC to select one entry of a table of 2-bit saturating counters. Because the history is part of the index, branches whose outcomes depend on one another share training state.

A lookup presents a fetch PC. One clock later the block returns a predicted direction and the table index it used. The pipeline carries that index along with the branch. When the branch resolves, the pipeline sends back the outcome and the saved index. The addressed counter is trained, and the outcome is shifted into the history. The history changes only at resolution. Repairing speculative history, computing targets and flushing the pipeline are left to other blocks.

Top module: `gbp_predictor`

## Requirements
- R1: After reset every counter holds 1 and the history holds 0. Every lookup then predicts not-taken (pred_taken=0), and pred_idx equals the PC index field.
- R2: The index is PC bits [IDX_W+1:2] XOR the history, zero-extended at its upper end, so the history sits in the low index bits. PC bits [1:0] and the PC bits above IDX_W+1 have no effect.
- R3: A taken update adds one to the addressed counter and stops at 3. A not-taken update after saturation at 3 leaves the counter at 2 (still taken).
- R4: A not-taken update subtracts one from the addressed counter and stops at 0. A taken update after saturation at 0 leaves the counter at 1 (still not-taken).
- R5: pred_taken is the upper bit of the selected counter: values 2 and 3 predict taken, values 0 and 1 predict not-taken.
- R6: Each accepted update shifts the history left by one. The outcome enters at bit 0 (taken = 1), and the oldest bit is dropped.
- R7: pred_valid is high exactly in the cycle after a cycle in which lk_valid was high. pred_taken and pred_idx belong to that lookup.
- R8: An update trains the entry named by upd_idx, whatever the history is at that moment.
- R9: A lookup and an update in the same cycle see the state from before the update, for both the counter and the history used in the index.
- R10: While upd_valid is low, upd_taken and upd_idx are ignored: no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch PC of the lookup |
| pred_valid | output | 1 | Prediction result is valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index the prediction used |
| upd_valid | input | 1 | Resolved-branch update this cycle |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_idx | input | IDX_W | Index saved from the prediction |

## Verification
A lookup's result is due at the first rising edge after lk_valid is sampled. An update is visible to a lookup presented in the following cycle: both the trained counter and the shifted history appear there.

The bench drives every input on the falling edge and computes its expected values at that point from its own model state. It then samples 2 ns after the next rising edge, so each check falls exactly one register stage after its stimulus. Same-cycle lookup and update pairs are scored against the model state from before the update is applied.

// File: rtl/gbp_pkg.sv
`timescale 1ns/1ps
package gbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // saturating step of one counter toward the resolved outcome
  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  // direction carried by a counter: upper half means taken
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/gbp_history.sv
`timescale 1ns/1ps
module gbp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_d = shift_bit;
    end else begin : g_multi
      assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  // R10: nothing moves without an accepted update
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  // R6: newest outcome lands at bit 0
  p_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(shift_bit));

  generate
    if (HIST_W > 1) begin : g_age_chk
      // R6: every bit ages by one position
      p_age_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
    end
  endgenerate
endmodule

// File: rtl/gbp_index.sv
`timescale 1ns/1ps
module gbp_index #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 11,
  parameter int HIST_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = IDX_W + PC_LSB - 1;

  logic [IDX_W-1:0] pc_field;
  logic [IDX_W-1:0] hist_ext;
  logic             unused_pc_bits;

  assign pc_field       = pc[PC_MSB:PC_LSB];
  assign unused_pc_bits = ^{pc[PC_W-1:PC_MSB+1], pc[PC_LSB-1:0]};

  generate
    if (HIST_W == IDX_W) begin : g_full
      assign hist_ext = hist;
    end else if (HIST_W < IDX_W) begin : g_short
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
    end else begin : g_long
      logic unused_hist_hi;
      assign hist_ext       = hist[IDX_W-1:0];
      assign unused_hist_hi = ^hist[HIST_W-1:IDX_W];
    end
  endgenerate

  assign idx = pc_field ^ hist_ext;
endmodule

// File: rtl/gbp_pht.sv
`timescale 1ns/1ps
module gbp_pht
  import gbp_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  // named events for the checks
  ctr_t wr_old;
  ctr_t wr_new;
  logic rd_wr_clash;

  assign wr_old      = tbl[wr_idx];
  assign wr_new      = ctr_next(wr_old, wr_taken);
  assign rd_wr_clash = rd_en && wr_en && (rd_idx == wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_ctr_q <= CTR_INIT;
    else if (rd_en) rd_ctr_q <= tbl[rd_idx];
  end

  // R3: taken never wraps a counter to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |-> (wr_new != CTR_MIN && wr_new >= wr_old));

  // R4: not-taken never wraps a counter to three
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |-> (wr_new != CTR_MAX && wr_new <= wr_old));

  // R9: colliding read returns the value before the write
  p_read_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr_clash |=> rd_ctr_q == $past(wr_old));
endmodule

// File: rtl/gbp_predictor.sv
`timescale 1ns/1ps
module gbp_predictor
  import gbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 11,
  parameter int HIST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_idx
);
  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_idx;
  ctr_t              lk_ctr_q;

  gbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist_q    (hist_q)
  );

  gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_index (
    .pc   (lk_pc),
    .hist (hist_q),
    .idx  (lk_idx)
  );

  gbp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (lk_valid),
    .rd_idx   (lk_idx),
    .rd_ctr_q (lk_ctr_q),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_idx   <= '0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) pred_idx <= lk_idx;
    end
  end

  assign pred_taken = ctr_dir(lk_ctr_q);

  // R7: one result per lookup, one cycle later
  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);
endmodule

// File: tb/gbp_predictor_tb_top.sv
`timescale 1ns/1ps
module gbp_predictor_tb_top;
  localparam int PW = 16;
  localparam int IW = 5;
  localparam int HW = 3;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid;
  logic [PW-1:0] lk_pc;
  logic          pred_valid;
  logic          pred_taken;
  logic [IW-1:0] pred_idx;
  logic          upd_valid;
  logic          upd_taken;
  logic [IW-1:0] upd_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_ctr [NE];
  int m_hist;

  always #10 clk = ~clk;

  gbp_predictor #(.PC_W(PW), .IDX_W(IW), .HIST_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_idx(pred_idx),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_idx(upd_idx)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // PC whose index field selects target under the current model history
  function automatic logic [PW-1:0] pc_at(input int target);
    return PW'(((target ^ m_hist) % NE) * 4);
  endfunction

  task automatic step(input bit lkv, input logic [PW-1:0] pc, input bit uv,
                      input bit ut, input int ui, input string tag);
    int e_idx;
    int e_tk;
    @(negedge clk);
    lk_valid  = lkv;
    lk_pc     = pc;
    upd_valid = uv;
    upd_taken = ut;
    upd_idx   = IW'(ui);
    e_idx = ((int'(pc) / 4) % NE) ^ m_hist;
    e_tk  = (m_ctr[e_idx] >= 2) ? 1 : 0;
    if (uv) begin
      if (ut) m_ctr[ui] = (m_ctr[ui] < 3) ? m_ctr[ui] + 1 : 3;
      else    m_ctr[ui] = (m_ctr[ui] > 0) ? m_ctr[ui] - 1 : 0;
      m_hist = ((m_hist * 2) + (ut ? 1 : 0)) % (1 << HW);
    end
    @(posedge clk);
    #2;
    chk(tag, "pred_valid", int'(pred_valid), int'(lkv));
    if (lkv) begin
      chk(tag, "pred_idx", int'(pred_idx), e_idx);
      chk(tag, "pred_taken", int'(pred_taken), e_tk);
    end
  endtask

  task automatic look(input int target, input string tag);
    step(1'b1, pc_at(target), 1'b0, 1'b0, 0, tag);
  endtask

  task automatic train(input int target, input bit ut, input string tag);
    step(1'b0, '0, 1'b1, ut, target, tag);
    look(target, tag);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0;
    upd_valid = 1'b0; upd_taken = 1'b0; upd_idx = '0;
    for (int i = 0; i < NE; i++) m_ctr[i] = 1;
    m_hist = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R7", "pred_valid in reset", int'(pred_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, every index predicts not-taken
    for (int i = 0; i < NE; i++) step(1'b1, PW'(i * 4), 1'b0, 1'b0, 0, "R1");

    // R2: stray PC bits below bit 2 and above the field are ignored
    for (int i = 0; i < NE; i++)
      step(1'b1, PW'(16'hA000 | (i * 4) | (i % 4)), 1'b0, 1'b0, 0, "R2");

    // R3 R4 R5 R8: full saturation walk of every entry
    for (int i = 0; i < NE; i++) begin
      for (int k = 0; k < 4; k++) train(i, 1'b1, "R3");
      train(i, 1'b0, "R3");
      for (int k = 0; k < 4; k++) train(i, 1'b0, "R4");
      train(i, 1'b1, "R4");
      look((i + 1) % NE, "R8");
    end

    // R5: entry driven to 2 predicts taken, neighbours keep their own value
    train(7, 1'b1, "R5");
    look(6, "R5");

    // R6: history visible through pred_idx at a PC field of zero
    for (int k = 0; k < 12; k++) begin
      step(1'b0, '0, 1'b1, (k % 3) != 1, (k * 5) % NE, "R6");
      step(1'b1, '0, 1'b0, 1'b0, 0, "R6");
      chk("R6", "history in idx", int'(pred_idx), m_hist);
    end

    // R9: lookup and update on the same entry in the same cycle
    for (int i = 0; i < 8; i++) begin
      step(1'b1, pc_at(i), 1'b1, 1'b1, i, "R9");
      look(i, "R9");
      step(1'b1, pc_at(i), 1'b1, 1'b0, i, "R9");
      look(i, "R9");
    end

    // R10: update fields without upd_valid change nothing
    for (int i = 0; i < NE; i++) begin
      step(1'b0, '0, 1'b0, 1'b1, i, "R10");
      look(i, "R10");
      step(1'b1, '0, 1'b0, 1'b0, 0, "R10");
      chk("R10", "history held", int'(pred_idx), m_hist);
    end

    // R7: idle cycles give no result
    for (int k = 0; k < 4; k++) step(1'b0, 16'h1234, 1'b0, 1'b0, 0, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule